// File: doc/BRIEF.md
# Per-Stage Radix Calibration Engine

This block is the digital side of a foreground calibration loop for a one-bit-per-stage pipelined converter whose inter-stage gain, its radix, sits deliberately below two. The radix of each stage is learned from the converter's own output. For the stage under test, the engine asks the converter for two conversions with the analog input held at zero. In the first conversion the stage's decision is forced to one, and in the second it is forced to zero. The engine rebuilds a code from each raw decision sequence with the radix values currently in the bank. The two codes should differ by exactly one LSB. Any excess or shortfall, scaled down by a programmable right shift, is subtracted from that stage's radix.

A start pulse launches a run. Within an iteration the engine visits every stage except the last one, in ascending order. It repeats this for a programmed number of iterations and then pulses `done`. Each decision sequence begins at the stage under test. It continues through the later stages, wraps round to the earlier ones, and ends with a second, unforced decision of the stage under test. A single shared reconstruction unit does the Horner-style multiply-accumulate, and it always reads the latest bank contents. Radix values are unsigned fixed point with `FRAC` fractional bits. Every write is limited to the range from 1.5 to 2.0.

Top module: `radcal_engine`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted, `busy`, `done`, `conv_req`, `force_en` and `rad_we` are all low.
- R2: A start pulse while idle, with a nonzero iteration count, raises `busy` on the next cycle. When the run finishes, `done` is high for exactly one cycle, and `busy` is already low in that cycle. A start pulse while busy is ignored.
- R3: Stages are numbered 0 to NSTAGE-1. Each iteration calibrates stages 0 to NSTAGE-2 in ascending order, with one bank write per stage. A run makes exactly count×(NSTAGE-1) writes, and the radix of stage NSTAGE-1 is never written.
- R4: Each stage takes two conversion requests, the first with `force_bit`=1 and the second with `force_bit`=0. `force_en` is high and `force_stage` names the stage throughout. `conv_req` stays high with stable `force_stage` and `force_bit` until `raw_valid` arrives.
- R5: `raw_seq[p]` is the decision at sequence position p (p = 0..NSTAGE), where position 0 is the stage under test i. The code is built as acc = bit0·ONE, then acc = floor(acc·g/ONE) + bit_p·ONE for p ≥ 1. Here g is the radix of stage (i+p-1) mod NSTAGE, and ONE = 2^FRAC is one LSB.
- R6: The new radix is r − ((D1 − D0 − ONE) >>> `step_shift`). D1 and D0 are the forced-one and forced-zero codes, and the shift is arithmetic.
- R7: Every written radix lies within [1.5·ONE, 2.0·ONE]. Results outside that range are set to the nearer bound.
- R8: Reconstruction for a stage uses radices already updated earlier in the same run, including those written earlier in the same iteration.
- R9: A start with an iteration count of zero produces a `done` pulse on the next cycle, with no conversion request and no bank write.
- R10: The reconstruction unit acknowledges only while a request from the sequencer is outstanding. No conversion is requested while a reconstruction result is pending. No bank write occurs while forcing is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a calibration run when idle |
| iter_count | input | IW | Number of iterations, latched at start |
| step_shift | input | SHW | Right shift applied to the error (update step) |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| conv_req | output | 1 | Requests one forced conversion |
| force_en | output | 1 | Holds the input at zero and forces one stage decision |
| force_stage | output | SW | Index of the stage whose decision is forced |
| force_bit | output | 1 | Value forced on that stage's decision |
| raw_valid | input | 1 | Raw decision sequence valid, ends a request |
| raw_seq | input | NSTAGE+1 | Raw decisions, bit p = sequence position p |
| rad_addr | output | SW | Radix bank address |
| rad_rdata | input | RW | Radix read data (combinational read) |
| rad_we | output | 1 | Radix bank write enable |
| rad_wdata | output | RW | Updated radix |

## Verification
On every cycle, the assertions check the handshakes. They confirm that a conversion request stays steady until its data returns and that reconstruction acknowledges only a live request. They also check that writes never overlap forcing, that `done` is a lone pulse with `busy` low, and that each written radix stays inside the clamp window. The numeric content of each write can only be shown by the bench scenarios, because it depends on the decision sequences and on radices written earlier in the run. The same holds for the stage and forced-bit ordering, the iteration count, the idle behaviour of a zero count and the rejection of a second start. The bench sweeps every shift value from 0 to 7, pseudo-random sequences and sequences that push both clamp bounds.

// File: rtl/radcal_pkg.sv
package radcal_pkg;

  typedef enum logic [2:0] {
    CS_IDLE = 3'd0,
    CS_CONV = 3'd1,
    CS_REC  = 3'd2,
    CS_UPD  = 3'd3,
    CS_FIN  = 3'd4
  } cal_state_e;

endpackage

// File: rtl/radcal_recon.sv
module radcal_recon #(
  parameter int NSTAGE = 20,
  parameter int FRAC   = 14,
  parameter int SW     = 5,
  parameter int RW     = 16,
  parameter int AW     = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [SW-1:0]   stage,
  input  logic [NSTAGE:0] seq,
  output logic [SW-1:0]   rd_addr,
  input  logic [RW-1:0]   rd_data,
  output logic            ack,
  output logic [AW-1:0]   result
);

  localparam int PW  = $clog2(NSTAGE + 1);
  localparam int IXW = SW + 2;
  localparam int unsigned ONE_I = 1 << FRAC;

  logic          busy_q, ack_q;
  logic [PW-1:0] pos_q;
  logic [AW-1:0] acc_q, res_q;

  logic           start_rec, last_pos;
  logic [IXW-1:0] idx_raw, idx_wrap;
  logic [AW+RW-1:0] prod;
  logic [AW-1:0]  scaled, bit_term, acc_n;

  assign start_rec = req && !busy_q && !ack_q;
  assign last_pos  = (pos_q == PW'(NSTAGE));

  // stage whose gain sits between position p-1 and p
  always_comb begin
    idx_raw  = IXW'(stage) + IXW'(pos_q) - IXW'(1);
    idx_wrap = (idx_raw >= IXW'(NSTAGE)) ? (idx_raw - IXW'(NSTAGE)) : idx_raw;
    rd_addr  = (pos_q == '0) ? stage : SW'(idx_wrap);
  end

  always_comb begin
    prod     = {{RW{1'b0}}, acc_q} * {{AW{1'b0}}, rd_data};
    scaled   = AW'(prod >> FRAC);
    bit_term = seq[pos_q] ? AW'(ONE_I) : '0;
    acc_n    = (pos_q == '0) ? bit_term : (scaled + bit_term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      pos_q  <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else if (start_rec) begin
      busy_q <= 1'b1;
      ack_q  <= 1'b0;
      pos_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_n;
      if (last_pos) begin
        busy_q <= 1'b0;
        ack_q  <= 1'b1;
        res_q  <= acc_n;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end else begin
      ack_q <= 1'b0;
    end
  end

  assign ack    = ack_q;
  assign result = res_q;

endmodule

// File: rtl/radcal_update.sv
module radcal_update #(
  parameter int FRAC = 14,
  parameter int RW   = 16,
  parameter int AW   = 36,
  parameter int SHW  = 5
) (
  input  logic [AW-1:0]  code_one,
  input  logic [AW-1:0]  code_zero,
  input  logic [RW-1:0]  radix_old,
  input  logic [SHW-1:0] shift,
  output logic [RW-1:0]  radix_new
);

  localparam int EW = AW + 3;
  localparam int unsigned ONE_I = 1 << FRAC;
  localparam int unsigned LO_I  = 3 << (FRAC - 1);
  localparam int unsigned HI_I  = 2 << FRAC;

  logic signed [EW-1:0] diff, err, step, cand;

  always_comb begin
    diff = $signed(EW'(code_one)) - $signed(EW'(code_zero));
    err  = diff - $signed(EW'(ONE_I));
    step = err >>> shift;
    cand = $signed(EW'(radix_old)) - step;
    if (cand < $signed(EW'(LO_I)))
      radix_new = RW'(LO_I);
    else if (cand > $signed(EW'(HI_I)))
      radix_new = RW'(HI_I);
    else
      radix_new = cand[RW-1:0];
  end

endmodule

// File: rtl/radcal_ctrl.sv
module radcal_ctrl
  import radcal_pkg::*;
#(
  parameter int NSTAGE = 20,
  parameter int SW     = 5,
  parameter int AW     = 36,
  parameter int IW     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IW-1:0]   iter_count,
  input  logic            raw_valid,
  input  logic [NSTAGE:0] raw_seq,
  input  logic            rec_ack,
  input  logic [AW-1:0]   rec_result,
  output logic            busy,
  output logic            done,
  output logic            conv_req,
  output logic            force_en,
  output logic [SW-1:0]   stage,
  output logic            force_bit,
  output logic            rec_req,
  output logic [NSTAGE:0] seq,
  output logic            upd_en,
  output logic [AW-1:0]   code_one,
  output logic [AW-1:0]   code_zero
);

  localparam logic [SW-1:0] LAST_CAL = SW'(NSTAGE - 2);

  cal_state_e      state_q, state_d;
  logic [SW-1:0]   stg_q, stg_d;
  logic            fb_q, fb_d;
  logic [IW-1:0]   iter_q, iter_d, cnt_q;
  logic [NSTAGE:0] seq_q;
  logic [AW-1:0]   d1_q, d0_q;
  logic            ld_cnt, ld_seq, ld_d1, ld_d0;

  always_comb begin
    state_d = state_q;
    stg_d   = stg_q;
    fb_d    = fb_q;
    iter_d  = iter_q;
    ld_cnt  = 1'b0;
    ld_seq  = 1'b0;
    ld_d1   = 1'b0;
    ld_d0   = 1'b0;
    case (state_q)
      CS_IDLE: if (start) begin
        ld_cnt  = 1'b1;
        stg_d   = '0;
        fb_d    = 1'b1;
        iter_d  = '0;
        state_d = (iter_count == '0) ? CS_FIN : CS_CONV;
      end
      CS_CONV: if (raw_valid) begin
        ld_seq  = 1'b1;
        state_d = CS_REC;
      end
      CS_REC: if (rec_ack) begin
        if (fb_q) begin
          ld_d1   = 1'b1;
          fb_d    = 1'b0;
          state_d = CS_CONV;
        end else begin
          ld_d0   = 1'b1;
          state_d = CS_UPD;
        end
      end
      CS_UPD: begin
        fb_d = 1'b1;
        if (stg_q == LAST_CAL) begin
          stg_d = '0;
          if (iter_q == cnt_q - IW'(1)) begin
            state_d = CS_FIN;
          end else begin
            iter_d  = iter_q + IW'(1);
            state_d = CS_CONV;
          end
        end else begin
          stg_d   = stg_q + SW'(1);
          state_d = CS_CONV;
        end
      end
      CS_FIN:  state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      stg_q   <= '0;
      fb_q    <= 1'b1;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      stg_q   <= stg_d;
      fb_q    <= fb_d;
      iter_q  <= iter_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seq_q <= '0;
      d1_q  <= '0;
      d0_q  <= '0;
    end else begin
      if (ld_cnt) cnt_q <= iter_count;
      if (ld_seq) seq_q <= raw_seq;
      if (ld_d1)  d1_q  <= rec_result;
      if (ld_d0)  d0_q  <= rec_result;
    end
  end

  assign busy      = (state_q != CS_IDLE) && (state_q != CS_FIN);
  assign done      = (state_q == CS_FIN);
  assign conv_req  = (state_q == CS_CONV);
  assign force_en  = (state_q == CS_CONV) || (state_q == CS_REC);
  assign rec_req   = (state_q == CS_REC);
  assign upd_en    = (state_q == CS_UPD);
  assign stage     = stg_q;
  assign force_bit = fb_q;
  assign seq       = seq_q;
  assign code_one  = d1_q;
  assign code_zero = d0_q;

endmodule

// File: rtl/radcal_engine.sv
module radcal_engine #(
  parameter int NSTAGE = 20,
  parameter int FRAC   = 14,
  parameter int IW     = 16,
  parameter int SHW    = 5,
  parameter int SW     = $clog2(NSTAGE),
  parameter int RW     = FRAC + 2,
  parameter int AW     = NSTAGE + FRAC + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IW-1:0]   iter_count,
  input  logic [SHW-1:0]  step_shift,
  output logic            busy,
  output logic            done,
  output logic            conv_req,
  output logic            force_en,
  output logic [SW-1:0]   force_stage,
  output logic            force_bit,
  input  logic            raw_valid,
  input  logic [NSTAGE:0] raw_seq,
  output logic [SW-1:0]   rad_addr,
  input  logic [RW-1:0]   rad_rdata,
  output logic            rad_we,
  output logic [RW-1:0]   rad_wdata
);

  logic            rst_m, rst_s;
  logic            rec_req, rec_ack, upd_en;
  logic [SW-1:0]   stg, rec_addr;
  logic [NSTAGE:0] seq;
  logic [AW-1:0]   rec_result, code_one, code_zero;

  // reset asserts at once, releases after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  radcal_ctrl #(.NSTAGE(NSTAGE), .SW(SW), .AW(AW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .start(start), .iter_count(iter_count),
    .raw_valid(raw_valid), .raw_seq(raw_seq),
    .rec_ack(rec_ack), .rec_result(rec_result),
    .busy(busy), .done(done), .conv_req(conv_req), .force_en(force_en),
    .stage(stg), .force_bit(force_bit), .rec_req(rec_req), .seq(seq),
    .upd_en(upd_en), .code_one(code_one), .code_zero(code_zero)
  );

  radcal_recon #(.NSTAGE(NSTAGE), .FRAC(FRAC), .SW(SW), .RW(RW), .AW(AW)) u_recon (
    .clk(clk), .rst_n(rst_s), .req(rec_req), .stage(stg), .seq(seq),
    .rd_addr(rec_addr), .rd_data(rad_rdata), .ack(rec_ack), .result(rec_result)
  );

  radcal_update #(.FRAC(FRAC), .RW(RW), .AW(AW), .SHW(SHW)) u_update (
    .code_one(code_one), .code_zero(code_zero), .radix_old(rad_rdata),
    .shift(step_shift), .radix_new(rad_wdata)
  );

  assign rad_addr    = upd_en ? stg : rec_addr;
  assign rad_we      = upd_en;
  assign force_stage = stg;

endmodule

// File: rtl/radcal_engine_chk.sv
module radcal_engine_chk #(
  parameter int NSTAGE = 20,
  parameter int FRAC   = 14,
  parameter int SW     = 5,
  parameter int RW     = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          conv_req,
  input logic          raw_valid,
  input logic          force_en,
  input logic [SW-1:0] force_stage,
  input logic          force_bit,
  input logic          rad_we,
  input logic [RW-1:0] rad_wdata,
  input logic          rec_req,
  input logic          rec_ack
);

  localparam logic [RW-1:0] LO = RW'(3 << (FRAC - 1));
  localparam logic [RW-1:0] HI = RW'(2 << FRAC);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !raw_valid) |=> (conv_req && $stable(force_stage) && $stable(force_bit)));
  assert_req_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (force_en && busy));
  assert_stage_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |-> (force_stage <= SW'(NSTAGE - 2)));
  assert_clamp_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rad_we |-> (rad_wdata >= LO && rad_wdata <= HI));
  assert_ack_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ack |-> (rec_req && !conv_req));
  assert_write_unforced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rad_we |-> !force_en);

endmodule

bind radcal_engine radcal_engine_chk #(
  .NSTAGE(NSTAGE), .FRAC(FRAC), .SW(SW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_s), .busy(busy), .done(done), .conv_req(conv_req),
  .raw_valid(raw_valid), .force_en(force_en), .force_stage(force_stage),
  .force_bit(force_bit), .rad_we(rad_we), .rad_wdata(rad_wdata),
  .rec_req(rec_req), .rec_ack(rec_ack)
);

// File: tb/sim_radcal_engine.sv
`timescale 1ns/1ps
module sim_radcal_engine;

  localparam int N    = 4;
  localparam int FR   = 8;
  localparam int IW   = 8;
  localparam int SHW  = 4;
  localparam int SW   = 2;
  localparam int RW   = FR + 2;
  localparam int NCAL = N - 1;
  localparam longint ONE = 1 << FR;
  localparam longint LO  = 3 << (FR - 1);
  localparam longint HI  = 2 << FR;

  logic clk = 1'b0;
  logic rst_n, start, raw_valid;
  logic [IW-1:0]  iter_count;
  logic [SHW-1:0] step_shift;
  logic busy, done, conv_req, force_en, force_bit, rad_we;
  logic [SW-1:0]  force_stage, rad_addr;
  logic [N:0]     raw_seq;
  logic [RW-1:0]  rad_rdata, rad_wdata;

  logic [RW-1:0] mem [N];
  longint        model [N];
  logic [N:0]    s1 [N];
  logic [N:0]    s0 [N];
  int mode, conv_cnt, wr_cnt, checks, fails;
  logic [31:0] lcg;

  always #2.5 clk = ~clk;

  radcal_engine #(.NSTAGE(N), .FRAC(FR), .IW(IW), .SHW(SHW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
    .step_shift(step_shift), .busy(busy), .done(done), .conv_req(conv_req),
    .force_en(force_en), .force_stage(force_stage), .force_bit(force_bit),
    .raw_valid(raw_valid), .raw_seq(raw_seq), .rad_addr(rad_addr),
    .rad_rdata(rad_rdata), .rad_we(rad_we), .rad_wdata(rad_wdata)
  );

  assign rad_rdata = mem[rad_addr];
  always @(posedge clk) if (rad_we) mem[rad_addr] <= rad_wdata;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rebuild(input logic [N:0] sq, input int stg);
    longint acc = 0;
    for (int p = 0; p <= N; p++) begin
      if (p == 0) acc = sq[0] ? ONE : 0;
      else acc = ((acc * model[(stg + p - 1) % N]) >> FR) + (sq[p] ? ONE : 0);
    end
    return acc;
  endfunction

  // converter model: answers each request after two cycles
  initial begin
    raw_valid = 1'b0;
    raw_seq   = '0;
    lcg       = 32'h1234_5678;
    forever begin
      @(negedge clk);
      if (conv_req) begin
        logic [N:0] sq;
        chk(force_en == 1'b1, "R4 force_en", force_en, 1);
        chk(force_bit == ((conv_cnt % 2) == 0), "R4 force_bit order", force_bit, (conv_cnt % 2) == 0);
        chk(force_stage == SW'((conv_cnt / 2) % NCAL), "R3 stage order", force_stage, (conv_cnt / 2) % NCAL);
        repeat (2) @(negedge clk);
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        case (mode)
          1:       sq = force_bit ? '1 : '0;
          2:       sq = force_bit ? (N+1)'(1) : ~(N+1)'(1);
          default: sq = {lcg[20 +: N], force_bit};
        endcase
        if (force_bit) s1[force_stage] = sq; else s0[force_stage] = sq;
        raw_seq   = sq;
        raw_valid = 1'b1;
        conv_cnt++;
        @(negedge clk);
        raw_valid = 1'b0;
      end
    end
  end

  // bank write monitor: R5 R6 R8 numeric check
  initial begin
    forever begin
      @(negedge clk);
      if (rad_we) begin
        int stg;
        longint d1, d0, err, nr;
        stg = int'(rad_addr);
        chk(stg == wr_cnt % NCAL, "R3 write order", stg, wr_cnt % NCAL);
        d1  = rebuild(s1[stg], stg);
        d0  = rebuild(s0[stg], stg);
        err = d1 - d0 - ONE;
        nr  = model[stg] - (err >>> int'(step_shift));
        if (nr < LO) nr = LO;
        if (nr > HI) nr = HI;
        chk(longint'(rad_wdata) == nr, "R5 R6 R8 radix value", rad_wdata, nr);
        if (mode == 1 && wr_cnt == 0) chk(longint'(rad_wdata) == LO, "R7 low bound", rad_wdata, LO);
        if (mode == 2 && wr_cnt == 0) chk(longint'(rad_wdata) == HI, "R7 high bound", rad_wdata, HI);
        model[stg] = nr;
        wr_cnt++;
      end
    end
  end

  task automatic run(input int cnt, input int sh, input int md, input int init, input bit again);
    int t;
    for (int k = 0; k < N; k++) begin
      mem[k]   = RW'(init + (md == 0 ? 6 * k : 0));
      model[k] = longint'(mem[k]);
    end
    conv_cnt   = 0;
    wr_cnt     = 0;
    mode       = md;
    iter_count = IW'(cnt);
    step_shift = SHW'(sh);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      chk(done == 1'b1 && busy == 1'b0, "R9 zero count done", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R9 done single", done, 0);
      chk(conv_cnt == 0 && wr_cnt == 0, "R9 no activity", conv_cnt + wr_cnt, 0);
    end else begin
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      if (again) begin
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      t = 0;
      while (!done && t < 20000) begin
        @(negedge clk);
        t++;
      end
      chk(done == 1'b1 && busy == 1'b0, "R2 done with busy low", {done, busy}, 2);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R2 done one cycle", {done, busy}, 0);
      chk(wr_cnt == cnt * NCAL, "R3 write count", wr_cnt, cnt * NCAL);
      chk(conv_cnt == 2 * cnt * NCAL, "R4 conversion count", conv_cnt, 2 * cnt * NCAL);
      chk(longint'(mem[N-1]) == model[N-1], "R3 last stage untouched", mem[N-1], model[N-1]);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; mode = 0; conv_cnt = 0; wr_cnt = 0;
    rst_n = 1'b0; start = 1'b0; iter_count = '0; step_shift = '0;
    for (int k = 0; k < N; k++) begin
      mem[k] = RW'(448); model[k] = 448; s1[k] = '0; s0[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, conv_req, force_en, rad_we} == 5'b0, "R1 reset outputs",
        {busy, done, conv_req, force_en, rad_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, conv_req, force_en, rad_we} == 5'b0, "R1 idle outputs",
        {busy, done, conv_req, force_en, rad_we}, 0);
    run(3, 4, 0, 448, 1'b1);
    for (int sh = 0; sh < 8; sh++) run(1, sh, 0, 430 + 4 * sh, 1'b0);
    run(4, 2, 0, 470, 1'b0);
    run(1, 0, 1, 512, 1'b0);
    run(1, 0, 2, 384, 1'b0);
    run(0, 3, 0, 448, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule